// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps the modem status byte of a serial port and the small modem-control register that sits beside it. Four modem input lines (clear-to-send, data-set-ready, carrier detect and ring) come in asynchronously. Each passes through a synchroniser and is then compared with the level last recorded. Any change latches a sticky change flag in the low half of the status byte. The ring line is the exception: its flag records only the end of a ring, when the line falls.

A read strobe returns the current byte and clears the change flags on the following edge. The OR of the flags is presented as a change-pending signal. That signal, gated by an external enable, forms the interrupt request for this source. When the loopback bit of the control register is set, a read returns a fixed rearrangement of the control outputs instead of the line levels.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status byte reads 8'hB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), the control register reads 5'b01000, and chgPending and irqReq are 0.
- R2: Status bits 7..4 hold carrier, ring, data-set-ready and clear-to-send in that order. A level change on an input pin shows in statRdData exactly SYNC_STAGES+1 rising edges after it is applied, and not before.
- R3: A change of carrier, data-set-ready or clear-to-send sets bit 3, bit 1 or bit 0 respectively. The flag stays set through any later changes until a normal-mode read clears it.
- R4: Bit 2 is set only when ring falls from 1 to 0. A rise of ring leaves it unchanged.
- R5: While statRdEn is high outside loopback, statRdData shows the current byte. Bits 3..0 are cleared on that clock edge and bits 7..4 are not disturbed.
- R6: If a synchronised line change reaches the register on the same edge as a clearing read, the read returns the value before the change and the new change flag survives the clear.
- R7: chgPending is 1 exactly when any of bits 3..0 is set, and irqReq equals chgPending AND msiEnable.
- R8: A write stores ctlWrData into the 5-bit control register, read back on ctlRdData. Its bits drive dtrOut (bit 0), rtsOut (bit 1), out1Out (bit 2), out2Out (bit 3) and loopOut (bit 4).
- R9: With loopOut high, statRdData is {control bit 3, control bit 2, control bit 0, control bit 1, 4'b0000}.
- R10: In loopback a read leaves the change flags untouched. The input lines are still tracked, so after loopback ends the status byte shows the lines and any flags raised meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctsIn | input | 1 | Clear-to-send line, asynchronous |
| dsrIn | input | 1 | Data-set-ready line, asynchronous |
| dcdIn | input | 1 | Carrier-detect line, asynchronous |
| riIn | input | 1 | Ring line, asynchronous |
| ctlWrEn | input | 1 | Write strobe for the control register |
| ctlWrData | input | 5 | Control register write value |
| statRdEn | input | 1 | Read strobe for the status byte |
| msiEnable | input | 1 | Enable for the status-change interrupt |
| statRdData | output | 8 | Status byte, or loopback image when loopOut is high |
| ctlRdData | output | 5 | Control register contents |
| chgPending | output | 1 | OR of the four change flags |
| irqReq | output | 1 | Status-change interrupt request |
| dtrOut | output | 1 | Terminal-ready output |
| rtsOut | output | 1 | Request-to-send output |
| out1Out | output | 1 | General output 1 |
| out2Out | output | 1 | General output 2 |
| loopOut | output | 1 | Loopback mode active |

## Verification
The assertions watch the per-cycle rules on every edge. These are the stickiness of the change flags when no clearing read happens, a cleared read leaving no flag unless a line also moved, the ring flag rising only together with a falling ring level, the interrupt gating, and the loopback bit rearrangement. Only the bench scenarios can show the exact synchroniser latency, a read and a line change colliding on one edge, and flags raised during loopback surviving until a later normal read. The bench checks these against a reference model of lines and flags that it keeps itself.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES  = 4;
  localparam int CTL_W  = 5;
  localparam int STAT_W = 8;
  // line order inside a nibble: {carrier, ring, dataSetReady, clearToSend}
  localparam logic [LINES-1:0] LINE_RST = 4'b1011;
  localparam logic [CTL_W-1:0] CTL_RST  = 5'b01000;
  localparam int RI_IDX = 2;

  typedef struct packed {
    logic clrDelta;
    logic loopSel;
  } msrStrobes_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stageQ <= {STAGES{RST_VAL}};
    else        stageQ <= {stageQ[STAGES-2:0], dIn};
  end

  assign qOut = stageQ[STAGES-1];
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             statRdEn,
  output logic [CTL_W-1:0] ctlQ,
  output msrStrobes_t      strb
);
  localparam int LOOP_BIT = CTL_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctlQ <= CTL_RST;
    else if (ctlWrEn) ctlQ <= ctlWrData;
  end

  always_comb begin
    strb.loopSel  = ctlQ[LOOP_BIT];
    strb.clrDelta = statRdEn && !ctlQ[LOOP_BIT];
  end
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  lineSync,
  input  logic [3:0]        ctlLow,
  input  msrStrobes_t       strb,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] rdData,
  output logic              chgPending
);
  logic [LINES-1:0]  lineOld;
  logic [LINES-1:0]  lineDiff;
  logic [LINES-1:0]  newFlag;
  logic [LINES-1:0]  keptFlag;
  logic [STAT_W-1:0] statusD;

  assign lineOld  = statusQ[STAT_W-1:LINES];
  assign lineDiff = lineOld ^ lineSync;

  // ring flag records only a falling ring level; the others record any change
  for (genvar i = 0; i < LINES; i++) begin : g_flag
    if (i == RI_IDX) begin : g_ring
      assign newFlag[i] = lineOld[i] && !lineSync[i];
    end else begin : g_level
      assign newFlag[i] = lineDiff[i];
    end
  end

  always_comb begin
    keptFlag = strb.clrDelta ? '0 : statusQ[LINES-1:0];
    statusD  = {lineSync, keptFlag | newFlag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusQ <= {LINE_RST, {LINES{1'b0}}};
    else        statusQ <= statusD;
  end

  // loopback image: out2, out1, dtr, rts in the upper nibble
  assign rdData = strb.loopSel ? {ctlLow[3], ctlLow[2], ctlLow[0], ctlLow[1], 4'b0000}
                               : statusQ;
  assign chgPending = |statusQ[LINES-1:0];
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              riIn,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  logic              statRdEn,
  input  logic              msiEnable,
  output logic [STAT_W-1:0] statRdData,
  output logic [CTL_W-1:0]  ctlRdData,
  output logic              chgPending,
  output logic              irqReq,
  output logic              dtrOut,
  output logic              rtsOut,
  output logic              out1Out,
  output logic              out2Out,
  output logic              loopOut
);
  logic [LINES-1:0]  lineSync;
  logic [CTL_W-1:0]  ctlQ;
  logic [STAT_W-1:0] statusQ;
  msrStrobes_t       strb;

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .dIn({dcdIn, riIn, dsrIn, ctsIn}),
    .qOut(lineSync)
  );

  msr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .statRdEn(statRdEn),
    .ctlQ(ctlQ), .strb(strb)
  );

  msr_datapath u_dp (
    .clk(clk), .rst_n(rst_n),
    .lineSync(lineSync), .ctlLow(ctlQ[3:0]), .strb(strb),
    .statusQ(statusQ), .rdData(statRdData), .chgPending(chgPending)
  );

  assign ctlRdData = ctlQ;
  assign irqReq    = chgPending && msiEnable;
  assign dtrOut    = ctlQ[0];
  assign rtsOut    = ctlQ[1];
  assign out1Out   = ctlQ[2];
  assign out2Out   = ctlQ[3];
  assign loopOut   = ctlQ[4];
endmodule

// File: rtl/modem_status_checker.sv
module modem_status_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       statRdEn,
  input logic       loopOut,
  input logic       msiEnable,
  input logic       irqReq,
  input logic       chgPending,
  input logic [7:0] statRdData,
  input logic [3:0] ctlLow,
  input logic [7:0] statusQ
);
  // R3: without a clearing read no change flag ever drops
  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(statRdEn && !loopOut) |=> ((statusQ[3:0] & $past(statusQ[3:0])) == $past(statusQ[3:0])));

  // R3: a clear-to-send level change is accompanied by its flag
  a_r3_cts_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(statusQ[4]) != statusQ[4]) |-> statusQ[0]);

  // R4: ring flag rises only together with a falling ring level
  a_r4_ring_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusQ[2]) |-> $fell(statusQ[6]));

  // R5: after a clearing read, flags remain only if some line moved
  a_r5_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (statRdEn && !loopOut) |=> ((statusQ[3:0] == 4'b0) || ($past(statusQ[7:4]) != statusQ[7:4])));

  // R7: interrupt gating
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !msiEnable |-> !irqReq);
  a_r7_no_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ[3:0] == 4'b0) |-> (!chgPending && !irqReq));

  // R9: loopback image of the control bits
  a_r9_loop_image: assert property (@(posedge clk) disable iff (!rst_n)
    loopOut |-> (statRdData == {ctlLow[3], ctlLow[2], ctlLow[0], ctlLow[1], 4'b0000}));
endmodule

bind modem_status_unit modem_status_checker i_chk (
  .clk(clk), .rst_n(rst_n), .statRdEn(statRdEn), .loopOut(loopOut),
  .msiEnable(msiEnable), .irqReq(irqReq), .chgPending(chgPending),
  .statRdData(statRdData), .ctlLow(ctlRdData[3:0]), .statusQ(statusQ)
);

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctsIn, dsrIn, dcdIn, riIn;
  logic ctlWrEn = 1'b0;
  logic [4:0] ctlWrData = '0;
  logic statRdEn = 1'b0;
  logic msiEnable = 1'b0;
  logic [7:0] statRdData;
  logic [4:0] ctlRdData;
  logic chgPending, irqReq, dtrOut, rtsOut, out1Out, out2Out, loopOut;

  int nChk = 0;
  int nErr = 0;
  logic [3:0] mUp  = 4'b1011;  // {carrier, ring, dsr, cts}
  logic [3:0] mDel = 4'b0000;
  logic [4:0] mCtl = 5'b01000;

  always #2 clk = ~clk;

  modem_status_unit #(.SYNC_STAGES(SYNC)) i_modem_status_unit (
    .clk(clk), .rst_n(rst_n), .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn), .riIn(riIn),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .statRdEn(statRdEn), .msiEnable(msiEnable),
    .statRdData(statRdData), .ctlRdData(ctlRdData), .chgPending(chgPending), .irqReq(irqReq),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .out1Out(out1Out), .out2Out(out2Out), .loopOut(loopOut)
  );

  function automatic logic [3:0] flagsFor(input logic [3:0] oldL, input logic [3:0] newL);
    logic [3:0] d;
    d = oldL ^ newL;
    d[2] = oldL[2] & ~newL[2];
    return d;
  endfunction

  function automatic logic [7:0] loopImage(input logic [4:0] c);
    return {c[3], c[2], c[0], c[1], 4'b0000};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic driveLines(input logic [3:0] v);
    {dcdIn, riIn, dsrIn, ctsIn} = v;
  endtask

  // drive at a falling edge, then let the change settle fully
  task automatic applyLines(input logic [3:0] v);
    driveLines(v);
    mDel = mDel | flagsFor(mUp, v);
    mUp = v;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic readNormal(input string tag);
    statRdEn = 1'b1;
    #1 chk(tag, statRdData, {mUp, mDel});
    @(negedge clk);
    statRdEn = 1'b0;
    mDel = 4'b0000;
  endtask

  task automatic writeCtl(input logic [4:0] v);
    ctlWrEn = 1'b1;
    ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
    mCtl = v;
  endtask

  task automatic chkIrq(input string tag);
    chk(tag, {6'b0, chgPending, irqReq}, {6'b0, |mDel, (|mDel) & msiEnable});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    driveLines(4'b1011);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", statRdData, 8'hB0);
    chk("R1 control", {3'b0, ctlRdData}, 8'h08);
    chk("R1 pending", {6'b0, chgPending, irqReq}, 8'h00);

    // R2 latency: carrier drops
    driveLines(4'b0011);
    repeat (SYNC) @(negedge clk);
    chk("R2 not yet", statRdData, 8'hB0);
    @(negedge clk);
    mDel = flagsFor(mUp, 4'b0011);
    mUp = 4'b0011;
    chk("R2 visible", statRdData, {mUp, mDel});
    chk("R3 carrier flag", {7'b0, statRdData[3]}, 8'h01);

    // R3 sticky through another change back
    applyLines(4'b1011);
    chk("R3 sticky", statRdData, {mUp, mDel});
    readNormal("R5 read value");
    chk("R5 cleared", statRdData, {mUp, 4'b0000});

    // R4 ring rise does not flag, fall does
    applyLines(4'b1111);
    chk("R4 ring rise", statRdData, 8'hF0);
    applyLines(4'b1011);
    chk("R4 ring fall", statRdData, 8'hB4);
    msiEnable = 1'b1;
    #1 chkIrq("R7 irq on");
    msiEnable = 1'b0;
    #1 chkIrq("R7 irq masked");
    @(negedge clk);
    readNormal("R5 ring read");

    // R6 change meets clearing read on the same edge
    applyLines(4'b1001);
    readNormal("R6 pre");
    driveLines(4'b1000);
    repeat (SYNC) @(negedge clk);
    statRdEn = 1'b1;
    #1 chk("R6 read old", statRdData, 8'h90);
    @(negedge clk);
    statRdEn = 1'b0;
    mDel = flagsFor(mUp, 4'b1000);
    mUp = 4'b1000;
    chk("R6 flag kept", statRdData, {mUp, mDel});
    readNormal("R6 drain");

    // R8 control register and pins
    writeCtl(5'b00101);
    chk("R8 readback", {3'b0, ctlRdData}, {3'b0, mCtl});
    chk("R8 pins", {3'b0, loopOut, out2Out, out1Out, rtsOut, dtrOut}, {3'b0, mCtl});

    // R9 / R10 loopback
    applyLines(4'b1010);
    writeCtl(5'b11010);
    chk("R8 loop pin", {7'b0, loopOut}, 8'h01);
    chk("R9 image", statRdData, loopImage(mCtl));
    writeCtl(5'b10101);
    chk("R9 image 2", statRdData, loopImage(mCtl));
    statRdEn = 1'b1;
    #1 chk("R9 loop read", statRdData, loopImage(mCtl));
    @(negedge clk);
    statRdEn = 1'b0;
    applyLines(4'b0110);
    #1 chkIrq("R10 pending in loop");
    writeCtl(5'b00000);
    readNormal("R10 flags kept");

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [3:0] v;
      v = 4'($urandom);
      msiEnable = 1'($urandom);
      applyLines(v);
      chk("R2 R3 R4 random", statRdData, {mUp, mDel});
      chkIrq("R7 random");
      if (($urandom % 3) == 0) readNormal("R5 random read");
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule